// File: doc/BRIEF.md
# Memory Self-Test Read Checker

This block is the read half of a memory self-test. A write engine first fills a contiguous run of word addresses. It writes the word offset within the run as data, so the word at `base + k` holds `k`. After a start pulse, the checker asks the memory for the same run, one address at a time, in ascending order. It rebuilds the expected sequence from the offset of each returned word and compares every word against it. It then reports completion and the number of words that did not match.

The expected values are derived from offsets and not from addresses. A second write run that starts at a different base therefore shows up only where it overwrote the first run. For example, fill 64 words at base 16 and then 64 words at base 76. Checking base 16 then flags exactly the four shared words, 76 to 79, while checking base 76 finds none. The memory side is a request channel (valid, ready, address) and an in-order response channel (valid, ready, data). The checker never stalls the response channel.

Top module: `bist_read_checker`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `done` is 0, `errCount` is 0 and `cmdValid` is 0.
- R2: A start pulse accepted while no run is active latches `base` and `length`. The block then issues exactly `length` requests with addresses `base`, `base+1`, ... `base+length-1`, in that order. Each request holds its address steady with `cmdValid` high until `cmdReady` is seen.
- R3: The k-th accepted response word (k counting from 0) is expected to equal k, taken in its low `DATA_W` bits. Each mismatch raises `errCount` by exactly one, and a matching word leaves it unchanged.
- R4: `rdReady` is 1 in every cycle, including during reset.
- R5: `done` goes high in the cycle after the `length`-th response word is accepted, together with the final `errCount`. It is never high while requests or responses of the run are still outstanding. It then stays high until the next accepted start.
- R6: In the cycle after an accepted start, `done` is 0 and `errCount` is 0.
- R7: `errCount` saturates at all ones and never wraps to a smaller value within a run.
- R8: A run with `length` 0 issues no request, and `done` rises two cycles after the start pulse with `errCount` 0.
- R9: A start pulse during an active run is ignored. The run keeps its base, its length, its address order and its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a run |
| base | input | ADDR_W | First word address of the region |
| length | input | LEN_W | Number of words to check |
| done | output | 1 | Run finished, all words compared |
| errCount | output | ERR_W | Number of mismatching words, saturating |
| cmdValid | output | 1 | Read request valid |
| cmdReady | input | 1 | Memory accepts the request |
| cmdAddr | output | ADDR_W | Word address of the request |
| rdValid | input | 1 | Response word valid |
| rdReady | output | 1 | Checker accepts response (always 1) |
| rdData | input | DATA_W | Response word |

## Verification
A wrong request offset appears on `cmdAddr` at the very handshake where it occurs, and the bench's address tracker flags it. A drifted expected offset makes every later word of a clean region miscompare, so `errCount` turns nonzero on the next response. An off-by-one completion count shows up as `done` rising before or after the last response, which the response counter catches at the cycle `done` is first seen. A wrapping or non-clearing error counter shows up in the narrow-counter instance, or in the run that follows an erroneous one.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } chkState_t;

  // Strobes from control to datapath, all valid for one cycle.
  typedef struct packed {
    logic load;   // accepted start: latch base, clear offsets and errors
    logic issue;  // request handshake this cycle
    logic beat;   // response word accepted this cycle
  } chkStrobe_t;

endpackage

// File: rtl/bist_chk_ctrl.sv
module bist_chk_ctrl
  import bist_chk_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] length,
  input  logic             cmdReady,
  input  logic             rdValid,
  output chkStrobe_t       strobe,
  output logic             cmdValid,
  output logic             done
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  chkState_t        state;
  chkState_t        stateNext;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] issueCnt;
  logic [LEN_W-1:0] recvCnt;
  logic             running;
  logic             startOk;
  logic             issueFire;
  logic             beatFire;
  logic             lastBeat;
  logic             emptyRun;

  always_comb begin
    running   = (state == ST_RUN);
    startOk   = start && !running;
    cmdValid  = running && (issueCnt != lenReg);
    issueFire = cmdValid && cmdReady;
    beatFire  = running && rdValid && (recvCnt != lenReg);
    lastBeat  = beatFire && ((recvCnt + LEN_ONE) == lenReg);
    emptyRun  = running && (lenReg == '0);
    strobe.load  = startOk;
    strobe.issue = issueFire;
    strobe.beat  = beatFire;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startOk) stateNext = ST_RUN;
      ST_RUN:  if (emptyRun || lastBeat) stateNext = ST_DONE;
      ST_DONE: if (startOk) stateNext = ST_RUN;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      lenReg   <= '0;
      issueCnt <= '0;
      recvCnt  <= '0;
    end else begin
      state <= stateNext;
      if (startOk) begin
        lenReg   <= length;
        issueCnt <= '0;
        recvCnt  <= '0;
      end else begin
        if (issueFire) issueCnt <= issueCnt + LEN_ONE;
        if (beatFire)  recvCnt  <= recvCnt + LEN_ONE;
      end
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/bist_chk_dpath.sv
module bist_chk_dpath
  import bist_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  chkStrobe_t        strobe,
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [ERR_W-1:0]  errCount
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [DATA_W-1:0] DATA_ONE = DATA_W'(1);
  localparam logic [ERR_W-1:0]  ERR_ONE  = ERR_W'(1);
  localparam logic [ERR_W-1:0]  ERR_MAX  = '1;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] expWord;
  logic              mismatch;
  logic              errFull;

  // The expected word is the offset of the response within the run.
  assign mismatch = strobe.beat && (rdData != expWord);
  assign errFull  = (errCount == ERR_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      expWord <= '0;
    end else if (strobe.load) begin
      addrReg <= base;
      expWord <= '0;
    end else begin
      if (strobe.issue) addrReg <= addrReg + ADDR_ONE;
      if (strobe.beat)  expWord <= expWord + DATA_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.load) begin
      errCount <= '0;
    end else if (mismatch && !errFull) begin
      errCount <= errCount + ERR_ONE;
    end
  end

  assign cmdAddr = addrReg;

endmodule

// File: rtl/bist_read_checker.sv
module bist_read_checker
  import bist_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32,
  parameter int ERR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  length,
  output logic              done,
  output logic [ERR_W-1:0]  errCount,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [DATA_W-1:0] rdData
);

  chkStrobe_t strobe;

  bist_chk_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .length   (length),
    .cmdReady (cmdReady),
    .rdValid  (rdValid),
    .strobe   (strobe),
    .cmdValid (cmdValid),
    .done     (done)
  );

  bist_chk_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .base     (base),
    .rdData   (rdData),
    .cmdAddr  (cmdAddr),
    .errCount (errCount)
  );

  // Responses are never back-pressured.
  assign rdReady = 1'b1;

endmodule

// File: rtl/bist_read_checker_sva.sv
module bist_read_checker_sva #(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic [ERR_W-1:0]  errCount,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              rdReady
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!done && errCount == '0 && !cmdValid));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdReady && !start) |=> (cmdValid && $stable(cmdAddr)));

  assert_err_step_R3: assert property (@(posedge clk) disable iff (rst)
    !start |=> ({1'b0, errCount} <= {1'b0, $past(errCount)} + (ERR_W+1)'(1)));

  assert_always_ready_R4: assert property (@(posedge clk) rdReady);

  assert_done_no_req_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmdValid);

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !cmdValid && (done || errCount == '0 || !done)) && !$past(cmdValid)
      && done |=> (!done && errCount == '0));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    !start |=> (errCount >= $past(errCount)));

endmodule

bind bist_read_checker bist_read_checker_sva #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) sva_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .done     (done),
  .errCount (errCount),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdAddr  (cmdAddr),
  .rdReady  (rdReady)
);

// File: tb/bist_read_checker_tb.sv
`timescale 1ns/1ps
module bist_read_checker_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 32;
  localparam int EW = 32;
  localparam int SAT_EW = 2;
  localparam int MEM_WORDS = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [LW-1:0] length = '0;
  logic          done;
  logic [EW-1:0] errCount;
  logic          cmdValid;
  logic          cmdReady;
  logic [AW-1:0] cmdAddr;
  logic          rdValid;
  logic          rdReady;
  logic [DW-1:0] rdData;

  bist_read_checker #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .ERR_W(EW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .base(base), .length(length),
    .done(done), .errCount(errCount), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData)
  );

  // Narrow-counter instance for saturation; its memory always returns all ones.
  logic              satStart = 1'b0;
  logic [LW-1:0]     satLength = '0;
  logic              satDone;
  logic [SAT_EW-1:0] satErr;
  logic              satCmdValid;
  logic [AW-1:0]     satCmdAddr;
  logic              satRdValid;
  logic              satRdReady;

  bist_read_checker #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .ERR_W(SAT_EW)) sat_i (
    .clk(clk), .rst(rst), .start(satStart), .base('0), .length(satLength),
    .done(satDone), .errCount(satErr), .cmdValid(satCmdValid), .cmdReady(1'b1),
    .cmdAddr(satCmdAddr), .rdValid(satRdValid), .rdReady(satRdReady),
    .rdData(32'hFFFF_FFFF)
  );

  always @(posedge clk) satRdValid <= rst ? 1'b0 : satCmdValid;

  // Memory model, in-order responses, optional random stalls.
  logic [DW-1:0] mem [MEM_WORDS];
  logic [DW-1:0] respQ [$];
  logic [15:0]   lfsr = 16'hACE1;
  logic          stallOn = 1'b0;
  logic          clearReq = 1'b0;
  logic [AW-1:0] trackBase = '0;
  logic [AW-1:0] expAddr;
  int            cmdSeen;
  int            beatSeen;
  int            addrErr;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst) begin
      respQ.delete();
      rdValid  <= 1'b0;
      rdData   <= '0;
      cmdReady <= 1'b0;
      cmdSeen  <= 0;
      beatSeen <= 0;
      addrErr  <= 0;
      expAddr  <= '0;
    end else begin
      if (rdValid && rdReady) begin
        void'(respQ.pop_front());
      end
      if (clearReq) begin
        cmdSeen  <= 0;
        beatSeen <= 0;
        addrErr  <= 0;
        expAddr  <= trackBase;
      end else begin
        if (rdValid && rdReady) beatSeen <= beatSeen + 1;
        if (cmdValid && cmdReady) begin
          respQ.push_back(mem[cmdAddr[7:0]]);
          cmdSeen <= cmdSeen + 1;
          if (cmdAddr != expAddr) addrErr <= addrErr + 1;
          expAddr <= expAddr + 1;
        end
      end
      cmdReady <= stallOn ? lfsr[0] : 1'b1;
      rdValid  <= (respQ.size() > 0) && (!stallOn || lfsr[3]);
      rdData   <= (respQ.size() > 0) ? respQ[0] : '0;
    end
  end

  int vecCnt  = 0;
  int failCnt = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vecCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int b, input int n);
    for (int k = 0; k < n; k++) mem[(b + k) % MEM_WORDS] = DW'(k);
  endtask

  // Start a run, check R6, wait for done and check R2/R5; returns the count.
  task automatic runCheck(input int b, input int n, input int midStartAfter, output longint errs);
    int waitCnt;
    @(negedge clk);
    base = AW'(b); length = LW'(n); start = 1'b1;
    trackBase = AW'(b); clearReq = 1'b1;
    @(negedge clk);
    start = 1'b0; clearReq = 1'b0;
    check(!done && errCount == 0, "R6 start clears done/errCount", {31'd0, done}, 0);
    waitCnt = 0;
    while (!done && waitCnt < 5000) begin
      if (midStartAfter > 0 && waitCnt == midStartAfter) begin
        base = 32'd3; length = 32'd5; start = 1'b1;   // R9 stray start
        @(negedge clk);
        start = 1'b0;
      end else begin
        @(negedge clk);
      end
      waitCnt++;
      check(rdReady, "R4 rdReady high", {31'd0, rdReady}, 1);
    end
    check(done, "R5 run finished", {31'd0, done}, 1);
    check(beatSeen == n, "R5 done after all beats", beatSeen, n);
    check(cmdSeen == n, "R2 request count", cmdSeen, n);
    check(addrErr == 0, "R2 address order", addrErr, 0);
    errs = errCount;
    repeat (3) @(negedge clk);
    check(done && errCount == EW'(errs), "R5 done holds", errCount, errs);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!done && errCount == 0 && !cmdValid, "R1 in reset", errCount, 0);
    check(rdReady, "R4 rdReady in reset", {31'd0, rdReady}, 1);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!done && errCount == 0 && !cmdValid, "R1 after release", {31'd0, done}, 0);
  endtask

  task automatic testClean(input bit stalls);
    longint e;
    stallOn = stalls;
    fill(16, 64);
    runCheck(16, 64, 0, e);
    check(e == 0, "R3 clean region", e, 0);
  endtask

  task automatic testOverlap();
    longint e;
    stallOn = 1'b1;
    fill(16, 64);
    fill(76, 64);
    runCheck(16, 64, 0, e);
    check(e == 4, "R3 overlap at old base", e, 4);
    runCheck(76, 64, 0, e);
    check(e == 0, "R3 new base clean (R6 cleared)", e, 0);
    stallOn = 1'b0;
    runCheck(16, 64, 0, e);
    check(e == 4, "R3 overlap without stalls", e, 4);
  endtask

  task automatic testEmpty();
    longint e;
    @(negedge clk);
    base = 32'd40; length = '0; start = 1'b1;
    trackBase = 32'd40; clearReq = 1'b1;
    @(negedge clk);
    start = 1'b0; clearReq = 1'b0;
    check(!done, "R8 done not yet", {31'd0, done}, 0);
    @(negedge clk);
    check(done && errCount == 0, "R8 done two cycles after start", {31'd0, done}, 1);
    check(cmdSeen == 0, "R8 no requests", cmdSeen, 0);
    e = errCount;
    check(e == 0, "R8 zero errors", e, 0);
  endtask

  task automatic testMidStart();
    longint e;
    stallOn = 1'b1;
    fill(100, 40);
    runCheck(100, 40, 10, e);
    check(e == 0, "R9 stray start ignored", e, 0);
  endtask

  task automatic testSaturate();
    int w;
    @(negedge clk); satLength = 32'd2; satStart = 1'b1;
    @(negedge clk); satStart = 1'b0;
    w = 0;
    while (!satDone && w < 200) begin @(negedge clk); w++; end
    check(satDone && satErr == 2, "R3 two mismatches counted", satErr, 2);
    @(negedge clk); satLength = 32'd8; satStart = 1'b1;
    @(negedge clk); satStart = 1'b0;
    check(satErr == 0, "R6 narrow counter cleared", satErr, 0);
    w = 0;
    while (!satDone && w < 200) begin @(negedge clk); w++; end
    check(satDone && satErr == 3, "R7 saturates at all ones", satErr, 3);
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'hDEAD_0000 | i;
    testReset();
    testClean(1'b0);
    testClean(1'b1);
    testOverlap();
    testEmpty();
    testMidStart();
    testSaturate();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule